// File: doc/BRIEF.md
# Single-Channel Peripheral DMA Engine

This block serves one peripheral with direct memory transfers. A channel request is raised while both the channel's pending flag and its transfer-enable mask are set. The pending flag is set by a hardware event from the peripheral or by a configuration write. The request is honoured only on an instruction-boundary strobe, and only when the channel priority is at least the processor's current priority. It is never honoured while the top-level interrupt service is active. Each grant moves exactly one data item over a request/ready memory port. The item goes either from memory to the peripheral or from the peripheral to memory. The table pointer then advances by one and the remaining-item counter drops by one.

When the counter runs out, the channel clears its own enable mask. If its interrupt mask allows, it then latches an end-of-block flag, which is presented as an interrupt subject to the same priority comparison. The effective address is 16 bits. The low byte is the table pointer. The high byte comes from one of two page registers, or is zero when the channel targets the register file instead of memory.

Top module: `dmac_channel`

## Requirements
- R1: `dma_req` is 1 exactly when both the pending flag and the enable mask are 1. The pending flag is set by a `hw_event` pulse, or written through CTRL bit 7. CTRL is `cfg_sel`=0 with layout [7] pending, [6] enable mask, [5] end-of-block interrupt mask, [4:2] channel priority, [1] page select, [0] register-file target.
- R2: `dma_grant` is asserted only in a cycle with `instr_end`=1, channel priority >= `cpu_prio`, and no transaction in flight.
- R3: No grant occurs while `top_irq_active` is 1.
- R4: The cycle after a grant, `mem_req` rises with `mem_addr` = {page, pointer}. The page is PAGE0 (`cfg_sel`=3) when CTRL[1]=0 and PAGE1 (`cfg_sel`=4) when CTRL[1]=1. When CTRL[0]=1 the high byte is 0 and `mem_space`=1. `mem_we` equals `per_dir` sampled at the grant (1 means peripheral to memory). `mem_wdata` is `per_wdata` sampled at the grant.
- R5: On the handshake cycle (`mem_req` and `mem_ready`), the pointer (`cfg_sel`=2) increments and the counter (`cfg_sel`=1) decrements, both modulo 256. For a read, `mem_rdata` is captured into `per_rdata`.
- R6: The transaction that brings the counter to zero clears the enable mask. If CTRL[5]=1 it also sets the end-of-block flag.
- R7: `eob_irq` is 1 while the end-of-block flag is set and channel priority >= `cpu_prio`. `eob_ack` clears the flag.
- R8: A request seen with the counter at zero issues no memory access. On the next edge it clears the enable mask and the pending flag, and sets the end-of-block flag if CTRL[5]=1.
- R9: `mem_req` stays high with a stable address and direction until `mem_ready`, then drops. The pending flag is cleared by the grant.
- R10: A `hw_event` in the same cycle as a grant leaves the pending flag set.
- R11: A write of a value above DFh to the register-slot location (`cfg_sel`=5) is ignored, so `chan_slot` keeps its value. Values up to DFh are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| hw_event | input | 1 | Peripheral event, sets pending |
| cpu_prio | input | 3 | Current processor priority |
| instr_end | input | 1 | Instruction-boundary strobe |
| top_irq_active | input | 1 | Top-level interrupt service running |
| eob_ack | input | 1 | Clears end-of-block flag |
| per_dir | input | 1 | 1: peripheral to memory, 0: memory to peripheral |
| per_wdata | input | 8 | Data from peripheral |
| per_rdata | output | 8 | Data delivered to peripheral |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_space | output | 1 | 1: register-file target |
| mem_addr | output | 16 | Effective address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| mem_ready | input | 1 | Memory access done |
| dma_req | output | 1 | Channel request |
| dma_grant | output | 1 | Grant pulse |
| eob_irq | output | 1 | End-of-block interrupt request |
| chan_count | output | 8 | Remaining transactions |
| chan_addr | output | 8 | Table pointer |
| chan_mask | output | 1 | Enable mask |
| chan_pend | output | 1 | Pending flag |
| chan_slot | output | 8 | Register-slot location |

## Verification
The collision of interest is a new peripheral event arriving in the very cycle a grant clears the pending flag. The bench provokes it by pulsing `hw_event` together with the boundary strobe on every transaction of a block except the last. The flag must read 1 after that edge, so the following transaction can be granted without a fresh event. On the last transaction the event is withheld, and the bench expects the flag to read 0 together with a cleared enable mask on completion. A second overlap is also exercised: counter exhaustion and the end-of-block flag occur on the same handshake edge as the pointer update, and all three are checked together.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int DW        = 8;
  localparam int PW        = 3;
  localparam int EW        = 2 * DW;
  localparam logic [DW-1:0] SLOT_LAST = 8'hDF;

  typedef enum logic [2:0] {
    SEL_CTRL  = 3'd0,
    SEL_COUNT = 3'd1,
    SEL_ADDR  = 3'd2,
    SEL_PAGE0 = 3'd3,
    SEL_PAGE1 = 3'd4,
    SEL_SLOT  = 3'd5
  } cfg_sel_e;

  typedef struct packed {
    logic          pend;
    logic          mask;
    logic          eob_en;
    logic [PW-1:0] prio;
    logic          page_sel;
    logic          reg_space;
  } ctrl_t;

  function automatic logic prio_ok(input logic [PW-1:0] chan, input logic [PW-1:0] cpu);
    return chan >= cpu;
  endfunction

  function automatic logic [DW-1:0] ptr_next(input logic [DW-1:0] p);
    return p + DW'(1);
  endfunction

  function automatic logic [DW-1:0] cnt_next(input logic [DW-1:0] c);
    return c - DW'(1);
  endfunction

  function automatic logic slot_ok(input logic [DW-1:0] s);
    return s <= SLOT_LAST;
  endfunction

  function automatic logic [EW-1:0] eff_addr(input logic reg_space, input logic sel,
                                             input logic [DW-1:0] p0, input logic [DW-1:0] p1,
                                             input logic [DW-1:0] ptr);
    logic [DW-1:0] hi;
    hi = reg_space ? '0 : (sel ? p1 : p0);
    return {hi, ptr};
  endfunction
endpackage

// File: rtl/dmac_regs.sv
module dmac_regs
  import dmac_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          hw_event,
  input  logic          grant,
  input  logic          zero_start,
  input  logic          step,
  input  logic          eob_ack,
  output ctrl_t         ctrl,
  output logic [DW-1:0] count,
  output logic [DW-1:0] addr,
  output logic [DW-1:0] page0,
  output logic [DW-1:0] page1,
  output logic [DW-1:0] slot,
  output logic          eob_flag,
  output logic          term_event
);
  logic ctrl_wr;
  assign ctrl_wr    = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_CTRL);
  assign term_event = (step && (count == DW'(1))) || zero_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      count    <= '0;
      addr     <= '0;
      page0    <= '0;
      page1    <= '0;
      slot     <= '0;
      eob_flag <= 1'b0;
    end else begin
      if (cfg_we) begin
        case (cfg_sel_e'(cfg_sel))
          SEL_CTRL: begin
            ctrl.eob_en    <= cfg_wdata[5];
            ctrl.prio      <= cfg_wdata[4:2];
            ctrl.page_sel  <= cfg_wdata[1];
            ctrl.reg_space <= cfg_wdata[0];
          end
          SEL_COUNT: count <= cfg_wdata;
          SEL_ADDR:  addr  <= cfg_wdata;
          SEL_PAGE0: page0 <= cfg_wdata;
          SEL_PAGE1: page1 <= cfg_wdata;
          SEL_SLOT:  if (slot_ok(cfg_wdata)) slot <= cfg_wdata;
          default: ;
        endcase
      end
      if (step) begin
        addr  <= ptr_next(addr);
        count <= cnt_next(count);
      end
      if (hw_event)                 ctrl.pend <= 1'b1;
      else if (ctrl_wr)             ctrl.pend <= cfg_wdata[7];
      else if (grant || zero_start) ctrl.pend <= 1'b0;
      if (term_event)   ctrl.mask <= 1'b0;
      else if (ctrl_wr) ctrl.mask <= cfg_wdata[6];
      if (term_event && ctrl.eob_en) eob_flag <= 1'b1;
      else if (eob_ack)              eob_flag <= 1'b0;
    end
  end

  a_r5_step_moves: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (addr == $past(addr) + DW'(1)) && (count == $past(count) - DW'(1)));
  a_r6_term_clears_mask: assert property (@(posedge clk) disable iff (!rst_n)
    term_event |=> !ctrl.mask);
  a_r10_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hw_event |=> ctrl.pend);
  a_r11_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
    slot <= SLOT_LAST);
endmodule

// File: rtl/dmac_arb.sv
module dmac_arb
  import dmac_pkg::*;
(
  input  logic          pend,
  input  logic          mask,
  input  logic [PW-1:0] chan_prio,
  input  logic [PW-1:0] cpu_prio,
  input  logic          instr_end,
  input  logic          top_irq,
  input  logic          busy,
  input  logic          count_zero,
  output logic          req,
  output logic          grant,
  output logic          zero_start
);
  assign req        = pend && mask;
  assign grant      = req && !busy && !count_zero && instr_end && !top_irq
                      && prio_ok(chan_prio, cpu_prio);
  assign zero_start = req && !busy && count_zero;
endmodule

// File: rtl/dmac_xfer.sv
module dmac_xfer
  import dmac_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          grant,
  input  logic          reg_space,
  input  logic          page_sel,
  input  logic [DW-1:0] page0,
  input  logic [DW-1:0] page1,
  input  logic [DW-1:0] ptr,
  input  logic          dir,
  input  logic [DW-1:0] per_wdata,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_space,
  output logic [EW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] per_rdata,
  output logic          step
);
  typedef enum logic {XS_IDLE, XS_BUSY} xs_e;
  xs_e state;

  assign busy    = (state == XS_BUSY);
  assign mem_req = busy;
  assign step    = busy && mem_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= XS_IDLE;
      mem_we    <= 1'b0;
      mem_space <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      per_rdata <= '0;
    end else begin
      case (state)
        XS_IDLE: if (grant) begin
          state     <= XS_BUSY;
          mem_we    <= dir;
          mem_space <= reg_space;
          mem_addr  <= eff_addr(reg_space, page_sel, page0, page1, ptr);
          mem_wdata <= per_wdata;
        end
        XS_BUSY: if (mem_ready) begin
          state <= XS_IDLE;
          if (!mem_we) per_rdata <= mem_rdata;
        end
        default: state <= XS_IDLE;
      endcase
    end
  end

  a_r9_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  a_r9_single_item: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> !mem_req);
  a_r2_no_grant_busy: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> !busy);
endmodule

// File: rtl/dmac_channel.sv
module dmac_channel
  import dmac_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [7:0]    cfg_wdata,
  input  logic          hw_event,
  input  logic [2:0]    cpu_prio,
  input  logic          instr_end,
  input  logic          top_irq_active,
  input  logic          eob_ack,
  input  logic          per_dir,
  input  logic [7:0]    per_wdata,
  output logic [7:0]    per_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_space,
  output logic [15:0]   mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  input  logic          mem_ready,
  output logic          dma_req,
  output logic          dma_grant,
  output logic          eob_irq,
  output logic [7:0]    chan_count,
  output logic [7:0]    chan_addr,
  output logic          chan_mask,
  output logic          chan_pend,
  output logic [7:0]    chan_slot
);
  ctrl_t         ctrl;
  logic [DW-1:0] page0, page1;
  logic          eob_flag, term_event, busy, step, zero_start;

  dmac_regs u_regs (
    .clk, .rst_n, .cfg_we, .cfg_sel, .cfg_wdata, .hw_event,
    .grant(dma_grant), .zero_start, .step, .eob_ack,
    .ctrl, .count(chan_count), .addr(chan_addr), .page0, .page1,
    .slot(chan_slot), .eob_flag, .term_event
  );

  dmac_arb u_arb (
    .pend(ctrl.pend), .mask(ctrl.mask), .chan_prio(ctrl.prio), .cpu_prio,
    .instr_end, .top_irq(top_irq_active), .busy,
    .count_zero(chan_count == '0), .req(dma_req), .grant(dma_grant), .zero_start
  );

  dmac_xfer u_xfer (
    .clk, .rst_n, .grant(dma_grant), .reg_space(ctrl.reg_space), .page_sel(ctrl.page_sel),
    .page0, .page1, .ptr(chan_addr), .dir(per_dir), .per_wdata, .mem_ready, .mem_rdata,
    .busy, .mem_req, .mem_we, .mem_space, .mem_addr, .mem_wdata, .per_rdata, .step
  );

  assign chan_mask = ctrl.mask;
  assign chan_pend = ctrl.pend;
  assign eob_irq   = eob_flag && prio_ok(ctrl.prio, cpu_prio);

  a_r2_grant_cond: assert property (@(posedge clk) disable iff (!rst_n)
    dma_grant |-> instr_end && (cpu_prio <= ctrl.prio));
  a_r3_top_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    top_irq_active |-> !dma_grant);
  a_r4_grant_launch: assert property (@(posedge clk) disable iff (!rst_n)
    dma_grant |=> mem_req);
  a_r8_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    zero_start |=> !mem_req && !chan_mask);
endmodule

// File: tb/test_dmac_channel.sv
`timescale 1ns/100ps
module test_dmac_channel;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0; logic [2:0] cfg_sel = 0; logic [7:0] cfg_wdata = 0;
  logic hw_event = 0; logic [2:0] cpu_prio = 0; logic instr_end = 0;
  logic top_irq_active = 0, eob_ack = 0, per_dir = 0;
  logic [7:0] per_wdata = 0, mem_rdata = 0; logic mem_ready = 0;
  logic [7:0] per_rdata, mem_wdata, chan_count, chan_addr, chan_slot;
  logic mem_req, mem_we, mem_space, dma_req, dma_grant, eob_irq, chan_mask, chan_pend;
  logic [15:0] mem_addr;
  int checks = 0, errors = 0;

  logic [7:0] m_addr, m_count, m_p0, m_p1;
  logic m_sel, m_space, m_dir, m_eob;
  logic [2:0] m_prio;

  always #2.5 clk = ~clk;

  dmac_channel i_dmac_channel (.*);

  function automatic logic [7:0] rd_fn(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction
  function automatic logic [15:0] ea_fn();
    return m_space ? {8'h00, m_addr} : {(m_sel ? m_p1 : m_p0), m_addr};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic cfg_write(input logic [2:0] s, input logic [7:0] d);
    cfg_we = 1; cfg_sel = s; cfg_wdata = d; tick(); cfg_we = 0;
  endtask

  task automatic setup_block();
    cfg_write(3'd3, m_p0); cfg_write(3'd4, m_p1);
    cfg_write(3'd2, m_addr); cfg_write(3'd1, m_count);
    cfg_write(3'd0, {1'b0, 1'b1, m_eob, m_prio, m_sel, m_space});
  endtask

  task automatic run_txn(input logic collide);
    logic [15:0] ea; logic [7:0] pw; int n;
    ea = ea_fn(); pw = 8'($urandom);
    per_dir = m_dir; per_wdata = pw; instr_end = 1; hw_event = collide; #0.5;
    chk("R2 grant at boundary", dma_grant, 1);
    tick(); instr_end = 0; hw_event = 0; per_wdata = ~pw; #0.5;
    chk("R9 mem_req raised", mem_req, 1);
    chk("R4 address", mem_addr, ea);
    chk("R4 direction", mem_we, m_dir);
    chk("R4 space", mem_space, m_space);
    if (m_dir) chk("R4 write data", mem_wdata, pw);
    chk("R10 pending after grant", chan_pend, collide);
    n = $urandom % 3;
    for (int k = 0; k < n; k++) begin
      tick(); #0.5;
      chk("R9 held", {mem_req, mem_addr}, {1'b1, ea});
    end
    mem_ready = 1; mem_rdata = rd_fn(ea); tick(); mem_ready = 0; #0.5;
    m_addr = m_addr + 8'd1; m_count = m_count - 8'd1;
    chk("R9 released", mem_req, 0);
    chk("R5 pointer", chan_addr, m_addr);
    chk("R5 counter", chan_count, m_count);
    if (!m_dir) chk("R5 read capture", per_rdata, rd_fn(ea));
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) tick();
    rst_n = 1; tick(); #0.5;
    chk("reset count", chan_count, 0); chk("reset addr", chan_addr, 0);
    chk("reset mask/pend", {chan_mask, chan_pend}, 0);
    chk("reset mem_req", mem_req, 0); chk("reset eob", eob_irq, 0);
    chk("reset slot", chan_slot, 0);

    // R11 slot range
    cfg_write(3'd5, 8'h40); #0.5; chk("R11 slot store", chan_slot, 8'h40);
    cfg_write(3'd5, 8'hE0); #0.5; chk("R11 slot reject", chan_slot, 8'h40);
    cfg_write(3'd5, 8'hDF); #0.5; chk("R11 slot edge", chan_slot, 8'hDF);

    // directed block with pointer wrap
    m_p0 = 8'h12; m_p1 = 8'h34; m_addr = 8'hFE; m_count = 8'd3;
    m_sel = 1; m_space = 0; m_dir = 0; m_eob = 1; m_prio = 3'd3;
    setup_block(); #0.5;
    chk("R1 mask alone no request", dma_req, 0);
    hw_event = 1; tick(); hw_event = 0; #0.5;
    chk("R1 request", dma_req, 1);
    cpu_prio = 3'd4; instr_end = 1; #0.5;
    chk("R2 priority too low", dma_grant, 0);
    cpu_prio = 3'd3; top_irq_active = 1; #0.5;
    chk("R3 top irq blocks", dma_grant, 0);
    top_irq_active = 0; instr_end = 0; #0.5;
    chk("R2 no boundary", dma_grant, 0);
    tick();
    run_txn(1); run_txn(1); run_txn(0);
    chk("R5 wrap", chan_addr, 8'h01);
    chk("R6 mask cleared", chan_mask, 0);
    chk("R6 eob", eob_irq, 1);
    cpu_prio = 3'd5; #0.5; chk("R7 eob masked by priority", eob_irq, 0);
    cpu_prio = 3'd2; #0.5; chk("R7 eob visible", eob_irq, 1);
    eob_ack = 1; tick(); eob_ack = 0; #0.5; chk("R7 eob cleared", eob_irq, 0);

    // R8 zero count start
    cfg_write(3'd1, 8'd0);
    cfg_write(3'd0, {1'b1, 1'b1, 1'b1, 3'd3, 1'b0, 1'b0}); #0.5;
    chk("R8 no access", mem_req, 0);
    tick(); #0.5;
    chk("R8 mask/pend cleared", {chan_mask, chan_pend}, 0);
    chk("R8 eob raised", eob_irq, 1);
    chk("R8 still no access", mem_req, 0);
    eob_ack = 1; tick(); eob_ack = 0;

    // random blocks
    for (int b = 0; b < 40; b++) begin
      m_p0 = 8'($urandom); m_p1 = 8'($urandom); m_addr = 8'($urandom);
      m_count = 8'(1 + $urandom % 4); m_sel = 1'($urandom); m_space = 1'($urandom);
      m_dir = 1'($urandom); m_eob = 1'($urandom); m_prio = 3'($urandom);
      cpu_prio = 3'($urandom % (int'(m_prio) + 1));
      setup_block();
      hw_event = 1; tick(); hw_event = 0; #0.5;
      chk("R1 request random", dma_req, 1);
      while (m_count != 0) run_txn(m_count != 8'd1);
      chk("R6 mask random", chan_mask, 0);
      chk("R6 R7 eob random", eob_irq, m_eob);
      eob_ack = 1; tick(); eob_ack = 0; #0.5;
      chk("R7 ack random", eob_irq, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule